// File: doc/BRIEF.md
# Page-mode DRAM access sequencer

This block sits between a synchronous request port and an asynchronous DRAM whose row and column addresses share one bus and whose data path is four bits wide. A client presents a 20-bit word address, a direction bit and write data under a valid/ready handshake. The block splits the address into a 10-bit row (upper half) and a 10-bit column (lower half). It then drives the active-low row strobe, column strobe, write enable and output enable, together with the shared address bus, in the order the DRAM needs. Read data comes back with a one-cycle valid pulse.

A row stays open after an access. A later request to the same row while the row strobe is still low is served as a column-only cycle. A request to another row first closes the row, waits out the precharge and then opens the new row. Refresh runs from a free-running interval counter. Each refresh is a column-before-row cycle with write enable held high, and it is served ahead of any new request. The open row is also closed before the row strobe could stay low longer than a set limit. All pulse widths and delays are parameters counted in system clocks.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: After reset, `dram_ras_n`, `dram_cas_n`, `dram_we_n` and `dram_oe_n` are 1, `dram_dq_oe` and `rd_valid` are 0, and `req_ready` is 1.
- R2: On the falling edge of `dram_ras_n` that opens a row for a request, `dram_addr` carries `req_addr[19:10]`. On the falling edge of `dram_cas_n` for that request, `dram_addr` carries `req_addr[9:0]`.
- R3: A read (`req_write`=0) has `dram_we_n`=1 and `dram_oe_n`=0 while `dram_cas_n` is low. `rd_data` is the value on `dram_dq_in` sampled RD_LAT clocks after `dram_cas_n` falls, and it is flagged by `rd_valid` for exactly one cycle.
- R4: A write (`req_write`=1) drives `dram_we_n` low and `dram_dq_oe` high with `req_wdata` on `dram_dq_out` before `dram_cas_n` falls (early write). `dram_oe_n` stays 1 whenever `dram_we_n` is 0.
- R5: A request whose row equals the open row, accepted while `dram_ras_n` is low, produces a column cycle with no new falling edge of `dram_ras_n`.
- R6: A request to a different row raises `dram_ras_n`. Every falling edge of `dram_ras_n` follows at least T_RP cycles with `dram_ras_n` high.
- R7: A refresh begins about every REF_INTERVAL clocks. In a refresh, `dram_cas_n` falls while `dram_ras_n` is high, then `dram_ras_n` falls, and `dram_we_n` stays 1 throughout.
- R8: Once a refresh is due, `req_ready` is 0 until the refresh has been issued, so no new request is accepted ahead of it.
- R9: `dram_ras_n` never stays low for more than T_RAS_MAX consecutive cycles. An idle open row is closed on its own.
- R10: `req_ready` is 0 while a column cycle, a row change or a refresh is in progress. In particular it is 0 whenever `dram_cas_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address, row in bits 19:10, column in 9:0 |
| req_wdata | input | 4 | Write data |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | 4 | Read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_dq_out | output | 4 | Data toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | 4 | Data from the DRAM |

## Verification
The assertions assume that a requester holds `req_addr`, `req_write` and `req_wdata` steady while `req_valid` waits for `req_ready`. They also assume the parameters are consistent: RD_LAT no larger than T_CAS, T_RAS_MAX well above one row-open plus column cycle, and REF_INTERVAL far longer than any access. Under those conditions a second refresh can never fall due before the first is served. The stimulus keeps to this by raising `req_valid` only between clock edges and lowering it only after it has seen `req_ready` high across an edge. The bench build sets a short row-low limit and a short refresh interval, so that row closing and refresh collide often with random traffic drawn from three rows.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RSETUP,
    ST_RCD,
    ST_CSETUP,
    ST_CAS,
    ST_OPEN,
    ST_PRE,
    ST_REF_CAS,
    ST_REF_RAS
  } fpm_state_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // cycle count of row-low time beyond which no new column cycle may start
  function automatic int close_point(input int t_ras_max, input int t_cas);
    return t_ras_max - t_cas - 4;
  endfunction

  // states in which a new request may be taken
  function automatic logic takes_request(input fpm_state_e s);
    return (s == ST_IDLE) || (s == ST_OPEN);
  endfunction

endpackage

// File: rtl/fpm_refresh_timer.sv
module fpm_refresh_timer #(
  parameter int INTERVAL = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  output logic due
);
  localparam int TW = $clog2(INTERVAL + 1);

  logic [TW-1:0] tcnt;
  logic          tick;

  assign tick = (tcnt == TW'(INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tcnt <= '0;
      due  <= 1'b0;
    end else begin
      tcnt <= tick ? '0 : tcnt + 1'b1;
      if (tick)     due <= 1'b1;
      else if (ack) due <= 1'b0;
    end
  end

  // R7
  ref_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> !due);

endmodule

// File: rtl/fpm_ras_guard.sv
module fpm_ras_guard #(
  parameter int T_RAS_MAX = 1000,
  parameter int CLOSE_AT  = 994,
  parameter int T_RP      = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_n,
  output logic close_req
);
  localparam int RW = $clog2(T_RAS_MAX + 2);
  localparam int HW = $clog2(T_RP + 2);

  logic [RW-1:0] low_cnt;
  logic [HW-1:0] high_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_cnt  <= '0;
      high_cnt <= HW'(T_RP);
    end else if (ras_n) begin
      low_cnt  <= '0;
      high_cnt <= (high_cnt >= HW'(T_RP)) ? high_cnt : high_cnt + 1'b1;
    end else begin
      high_cnt <= '0;
      low_cnt  <= (low_cnt == RW'(T_RAS_MAX + 1)) ? low_cnt : low_cnt + 1'b1;
    end
  end

  assign close_req = (low_cnt >= RW'(CLOSE_AT));

  // R9
  ras_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_cnt <= RW'(T_RAS_MAX));

  // R6
  precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (high_cnt >= HW'(T_RP)));

endmodule

// File: rtl/fpm_seq.sv
module fpm_seq
  import fpm_pkg::*;
#(
  parameter int ROW_W     = 10,
  parameter int COL_W     = 10,
  parameter int DQ_W      = 4,
  parameter int T_RCD     = 2,
  parameter int T_CAS     = 2,
  parameter int RD_LAT    = 2,
  parameter int T_RP      = 3,
  parameter int T_CSR     = 1,
  parameter int T_REF_RAS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [ROW_W+COL_W-1:0]   req_addr,
  input  logic [DQ_W-1:0]          req_wdata,
  output logic                     rd_valid,
  output logic [DQ_W-1:0]          rd_data,
  input  logic                     ref_due,
  output logic                     ref_start,
  input  logic                     close_req,
  output logic                     ras_n,
  output logic                     cas_n,
  output logic                     we_n,
  output logic                     oe_n,
  output logic [ROW_W-1:0]         mux_addr,
  output logic [DQ_W-1:0]          dq_out,
  output logic                     dq_oe,
  input  logic [DQ_W-1:0]          dq_in
);
  localparam int AW      = ROW_W + COL_W;
  localparam int CNT_MAX = max_of(max_of(T_RCD, T_CAS),
                                  max_of(max_of(T_RP, T_CSR), T_REF_RAS));
  localparam int CW      = $clog2(CNT_MAX + 1);

  function automatic logic [ROW_W-1:0] row_of(input logic [AW-1:0] a);
    return a[AW-1:COL_W];
  endfunction

  function automatic logic [ROW_W-1:0] col_of(input logic [AW-1:0] a);
    return ROW_W'(a[COL_W-1:0]);
  endfunction

  fpm_state_e        st;
  logic [CW-1:0]     cnt;
  logic              pend;
  logic              p_write;
  logic [AW-1:0]     p_addr;
  logic [DQ_W-1:0]   p_wdata;
  logic [ROW_W-1:0]  open_row;
  logic              row_open;

  logic accept;
  logic row_hit;
  logic rd_sample;

  assign req_ready = takes_request(st) && !ref_due &&
                     ((st == ST_IDLE) ? !pend : !close_req);
  assign accept    = req_valid && req_ready;
  assign row_hit   = row_open && (row_of(req_addr) == open_row);
  assign ref_start = (st == ST_IDLE) && ref_due;
  assign rd_sample = (st == ST_CAS) && !p_write && (cnt == CW'(RD_LAT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      pend     <= 1'b0;
      p_write  <= 1'b0;
      p_addr   <= '0;
      p_wdata  <= '0;
      open_row <= '0;
      row_open <= 1'b0;
      ras_n    <= 1'b1;
      cas_n    <= 1'b1;
      we_n     <= 1'b1;
      oe_n     <= 1'b1;
      mux_addr <= '0;
      dq_out   <= '0;
      dq_oe    <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (rd_sample) begin
        rd_valid <= 1'b1;
        rd_data  <= dq_in;
      end
      unique case (st)
        ST_IDLE: begin
          if (ref_due) begin
            cas_n <= 1'b0;
            cnt   <= CW'(T_CSR - 1);
            st    <= ST_REF_CAS;
          end else if (pend) begin
            mux_addr <= row_of(p_addr);
            st       <= ST_RSETUP;
          end else if (accept) begin
            pend     <= 1'b1;
            p_write  <= req_write;
            p_addr   <= req_addr;
            p_wdata  <= req_wdata;
            mux_addr <= row_of(req_addr);
            st       <= ST_RSETUP;
          end
        end
        ST_RSETUP: begin
          ras_n    <= 1'b0;
          open_row <= row_of(p_addr);
          row_open <= 1'b1;
          cnt      <= CW'(T_RCD - 1);
          st       <= ST_RCD;
        end
        ST_RCD: begin
          if (cnt == '0) begin
            mux_addr <= col_of(p_addr);
            we_n     <= !p_write;
            dq_oe    <= p_write;
            dq_out   <= p_wdata;
            st       <= ST_CSETUP;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_CSETUP: begin
          cas_n <= 1'b0;
          oe_n  <= !we_n;
          pend  <= 1'b0;
          cnt   <= '0;
          st    <= ST_CAS;
        end
        ST_CAS: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(T_CAS - 1)) begin
            cas_n <= 1'b1;
            oe_n  <= 1'b1;
            we_n  <= 1'b1;
            dq_oe <= 1'b0;
            st    <= ST_OPEN;
          end
        end
        ST_OPEN: begin
          if (close_req || ref_due) begin
            ras_n    <= 1'b1;
            row_open <= 1'b0;
            cnt      <= CW'(T_RP - 1);
            st       <= ST_PRE;
          end else if (accept) begin
            pend    <= 1'b1;
            p_write <= req_write;
            p_addr  <= req_addr;
            p_wdata <= req_wdata;
            if (row_hit) begin
              mux_addr <= col_of(req_addr);
              we_n     <= !req_write;
              dq_oe    <= req_write;
              dq_out   <= req_wdata;
              st       <= ST_CSETUP;
            end else begin
              ras_n    <= 1'b1;
              row_open <= 1'b0;
              cnt      <= CW'(T_RP - 1);
              st       <= ST_PRE;
            end
          end
        end
        ST_PRE: begin
          if (cnt == '0) st <= ST_IDLE;
          else           cnt <= cnt - 1'b1;
        end
        ST_REF_CAS: begin
          if (cnt == '0) begin
            ras_n <= 1'b0;
            cnt   <= CW'(T_REF_RAS - 1);
            st    <= ST_REF_RAS;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_REF_RAS: begin
          if (cnt == '0) begin
            ras_n <= 1'b1;
            cas_n <= 1'b1;
            cnt   <= CW'(T_RP - 1);
            st    <= ST_PRE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R4
  write_no_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> oe_n);

  // R4
  write_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && !we_n) |-> dq_oe);

  // R7
  cbr_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> we_n);

  // R7
  cbr_cas_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && ras_n) |-> we_n);

  // R3
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R3
  rd_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> !$past(oe_n));

  // R10
  ready_idle_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> cas_n);

  // R8
  ready_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_start |-> !req_ready);

endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
  import fpm_pkg::*;
#(
  parameter int ROW_W        = 10,
  parameter int COL_W        = 10,
  parameter int DQ_W         = 4,
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 2,
  parameter int RD_LAT       = 2,
  parameter int T_RP         = 3,
  parameter int T_CSR        = 1,
  parameter int T_REF_RAS    = 4,
  parameter int T_RAS_MAX    = 1000,
  parameter int REF_INTERVAL = 1560
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DQ_W-1:0]        req_wdata,
  output logic                   rd_valid,
  output logic [DQ_W-1:0]        rd_data,
  output logic                   dram_ras_n,
  output logic                   dram_cas_n,
  output logic                   dram_we_n,
  output logic                   dram_oe_n,
  output logic [ROW_W-1:0]       dram_addr,
  output logic [DQ_W-1:0]        dram_dq_out,
  output logic                   dram_dq_oe,
  input  logic [DQ_W-1:0]        dram_dq_in
);
  localparam int CLOSE_AT = close_point(T_RAS_MAX, T_CAS);

  logic ref_due;
  logic ref_start;
  logic close_req;

  fpm_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_ref (
    .clk   (clk),
    .rst_n (rst_n),
    .ack   (ref_start),
    .due   (ref_due)
  );

  fpm_ras_guard #(
    .T_RAS_MAX (T_RAS_MAX),
    .CLOSE_AT  (CLOSE_AT),
    .T_RP      (T_RP)
  ) u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .ras_n     (dram_ras_n),
    .close_req (close_req)
  );

  fpm_seq #(
    .ROW_W     (ROW_W),
    .COL_W     (COL_W),
    .DQ_W      (DQ_W),
    .T_RCD     (T_RCD),
    .T_CAS     (T_CAS),
    .RD_LAT    (RD_LAT),
    .T_RP      (T_RP),
    .T_CSR     (T_CSR),
    .T_REF_RAS (T_REF_RAS)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .ref_due   (ref_due),
    .ref_start (ref_start),
    .close_req (close_req),
    .ras_n     (dram_ras_n),
    .cas_n     (dram_cas_n),
    .we_n      (dram_we_n),
    .oe_n      (dram_oe_n),
    .mux_addr  (dram_addr),
    .dq_out    (dram_dq_out),
    .dq_oe     (dram_dq_oe),
    .dq_in     (dram_dq_in)
  );

  // R10
  ready_in_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_cas_n && dram_ras_n) |-> !req_ready);

endmodule

// File: tb/fpm_dram_ctrl_test.sv
module fpm_dram_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int T_RP       = 3;
  localparam int RD_LAT     = 2;
  localparam int T_RAS_MAX  = 40;
  localparam int REF_IVL    = 600;
  localparam int REF_SLACK  = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;
  logic        rd_valid;
  logic [3:0]  rd_data;
  logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [9:0]  dram_addr;
  logic [3:0]  dram_dq_out, dram_dq_in;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fpm_dram_ctrl #(
    .T_RP(T_RP), .RD_LAT(RD_LAT), .T_RAS_MAX(T_RAS_MAX), .REF_INTERVAL(REF_IVL)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
    .dram_addr(dram_addr), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
    .dram_dq_in(dram_dq_in)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] kidx(input logic [9:0] r, input logic [9:0] c);
    return {r[3:0], c[3:0]};
  endfunction

  function automatic logic [3:0] seed_val(input int i);
    return 4'((i * 7 + 3) & 15);
  endfunction

  // DRAM model
  logic [3:0] dmem [0:255];
  logic [3:0] shadow [0:255];
  logic [9:0] m_row = '0, m_col = '0;
  bit  p_ras = 1, p_cas = 1;
  int  ras_falls = 0, col_cnt = 0, ref_cnt = 0, rd_cnt = 0;
  int  ras_rise_cyc = 0, ras_fall_cyc = 0, cas_fall_cyc = 0, last_ref_cyc = 0;
  logic [3:0] last_rd = '0;

  initial for (int i = 0; i < 256; i++) begin
    dmem[i] = seed_val(i);
    shadow[i] = seed_val(i);
  end

  assign dram_dq_in = (!dram_ras_n && !dram_cas_n && !dram_oe_n) ?
                      dmem[kidx(m_row, m_col)] : 4'h0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_cas && !dram_cas_n && dram_ras_n) begin
        chk(dram_we_n == 1'b1, "R7 cbr we high", dram_we_n, 1);
        chk(req_ready == 1'b0, "R8 ready during refresh", req_ready, 0);
        if (ref_cnt > 0) begin
          chk((cyc - last_ref_cyc <= REF_IVL + REF_SLACK) &&
              (cyc - last_ref_cyc >= REF_IVL - REF_SLACK),
              "R7 refresh spacing", cyc - last_ref_cyc, REF_IVL);
        end
        last_ref_cyc = cyc;
        ref_cnt++;
      end
      if (p_ras && !dram_ras_n) begin
        if (!dram_cas_n) begin
          chk(dram_we_n == 1'b1, "R7 we at cbr row fall", dram_we_n, 1);
        end else begin
          m_row = dram_addr;
          ras_falls++;
        end
        chk(cyc - ras_rise_cyc >= T_RP, "R6 precharge", cyc - ras_rise_cyc, T_RP);
        ras_fall_cyc = cyc;
      end
      if (!p_ras && dram_ras_n) begin
        chk(cyc - ras_fall_cyc <= T_RAS_MAX, "R9 ras low time",
            cyc - ras_fall_cyc, T_RAS_MAX);
        ras_rise_cyc = cyc;
      end
      if (p_cas && !dram_cas_n && !dram_ras_n) begin
        m_col = dram_addr;
        col_cnt++;
        cas_fall_cyc = cyc;
        chk(req_ready == 1'b0, "R10 ready in column cycle", req_ready, 0);
        if (!dram_we_n) begin
          chk(dram_oe_n && dram_dq_oe, "R4 early write strobes",
              {dram_oe_n, dram_dq_oe}, 3);
          dmem[kidx(m_row, m_col)] = dram_dq_out;
        end else begin
          chk(dram_oe_n == 1'b0, "R3 oe low on read", dram_oe_n, 0);
        end
      end
      if (rd_valid) begin
        chk(cyc - cas_fall_cyc == RD_LAT, "R3 read latency",
            cyc - cas_fall_cyc, RD_LAT);
        last_rd = rd_data;
        rd_cnt++;
      end
    end
    p_ras = dram_ras_n;
    p_cas = dram_cas_n;
  end

  task automatic do_op(input bit wr, input logic [19:0] a, input logic [3:0] wd);
    int c0, r0, tmo;
    c0 = col_cnt;
    r0 = rd_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    tmo = 0;
    while (!req_ready && tmo < 200) begin @(negedge clk); tmo++; end
    @(negedge clk);
    req_valid = 1'b0;
    tmo = 0;
    while (col_cnt == c0 && tmo < 200) begin @(negedge clk); tmo++; end
    chk(m_row == a[19:10], "R2 row on bus", m_row, a[19:10]);
    chk(m_col == a[9:0], "R2 column on bus", m_col, a[9:0]);
    if (wr) begin
      shadow[kidx(a[19:10], a[9:0])] = wd;
    end else begin
      tmo = 0;
      while (rd_cnt == r0 && tmo < 50) begin @(negedge clk); tmo++; end
      chk(last_rd == shadow[kidx(a[19:10], a[9:0])], "R3 read data",
          last_rd, shadow[kidx(a[19:10], a[9:0])]);
    end
  endtask

  function automatic logic [9:0] pick_row(input int s);
    case (s % 3)
      0: return 10'h2A5;
      1: return 10'h15A;
      default: return 10'h3C3;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int rf0, rc0;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    chk({dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n} == 4'hF,
        "R1 strobes in reset", {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 15);
    rst_n = 1'b1;
    @(negedge clk);
    chk({dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n} == 4'hF,
        "R1 strobes after reset", {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 15);
    chk(dram_dq_oe == 1'b0 && rd_valid == 1'b0, "R1 data idle",
        {dram_dq_oe, rd_valid}, 0);
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);

    // unwritten word, then write and read back
    do_op(1'b0, {10'h2A5, 10'h011}, 4'h0);
    do_op(1'b1, {10'h2A5, 10'h012}, 4'hC);
    do_op(1'b0, {10'h2A5, 10'h012}, 4'h0);

    // R5 / R6 directly after a refresh
    rc0 = ref_cnt;
    while (ref_cnt == rc0) @(negedge clk);
    do_op(1'b0, {10'h15A, 10'h101}, 4'h0);
    rf0 = ras_falls;
    do_op(1'b1, {10'h15A, 10'h202}, 4'h5);
    chk(ras_falls == rf0, "R5 page hit keeps row", ras_falls, rf0);
    do_op(1'b0, {10'h3C3, 10'h303}, 4'h0);
    chk(ras_falls == rf0 + 1, "R6 miss reopens row", ras_falls, rf0 + 1);

    // R9 idle row closes by itself
    repeat (T_RAS_MAX + 10) @(negedge clk);
    chk(dram_ras_n == 1'b1, "R9 idle row closed", dram_ras_n, 1);

    for (int i = 0; i < 300; i++) begin
      logic [9:0] r;
      logic [9:0] c;
      r = pick_row(int'($urandom % 3));
      c = 10'($urandom);
      do_op(1'($urandom), {r, c}, 4'($urandom));
      if ((i % 50) == 49) repeat (int'($urandom % 30)) @(negedge clk);
    end

    chk(ref_cnt >= cyc / REF_IVL - 1, "R7 refresh count", ref_cnt, cyc / REF_IVL);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule